// File: doc/BRIEF.md
# Multi-Level Interrupt Priority Controller

This block collects a bus of asynchronous interrupt request lines into a pending register and masks that register with a software-written enable register. It then groups the lines into priority levels using a fixed membership mask for each level. The highest level that has at least one enabled pending line and lies strictly above the processor's current interrupt level is reported to the core. A single request output is asserted alongside that level.

Each implemented line is either level-type or edge-type. A level-type line's pending bit follows the synchronized request. An edge-type line's pending bit is set on a rising edge of the request and stays set until software clears it through a write-one-to-clear port. Lines on the request bus at or above the configured interrupt count are not implemented: their requests are dropped.

Top module: `irq_level_ctrl`

## Requirements
- R1: A level-type line (default lines 0, 2 and 4) has its pending bit set while its synchronized request is high and cleared when the request is low, so the reported level follows the request.
- R2: An edge-type line (default lines 1, 3 and 5) has its pending bit set by a rising edge of its request, and the bit stays set after the request drops.
- R3: Writing a 1 to bit i of the clear port clears the pending bit of edge-type line i. Writing to the bit of a level-type line has no effect.
- R4: Only pending lines whose enable bit is 1 take part in arbitration. A pending bit survives while its line is disabled, so enabling the line later raises the request.
- R5: Level L (1..NUM_LVL) is active when its membership mask intersects the enabled pending set. The reported level is the highest active level. Default masks: level 1 = lines 0, 6, 7; level 2 = lines 1, 2; level 3 = line 3; level 4 = lines 4, 5.
- R6: Only levels strictly greater than the current-level register are eligible. An active level equal to or below it is not reported.
- R7: When no eligible level is active, and after reset, the reported level is 0 and the request output is low.
- R8: Requests on lines with index at or above NUM_IRQ (default 6) change no state, even when those lines are enabled and belong to a level.
- R9: A write to the enable or current-level register shows at the outputs on the second rising edge counting the one that captures the write. A request change shows on the fourth rising edge counting the one that first samples it (two synchronizer stages, the pending register, then the output register).
- R10: A request held high after its edge-type pending bit was cleared does not set the bit again until the request drops and rises once more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | REQ_W | Raw asynchronous interrupt request lines |
| en_we | input | 1 | Enable register write strobe |
| en_wdata | input | REQ_W | New enable register value |
| cur_we | input | 1 | Current-level register write strobe |
| cur_wdata | input | LVL_W | New current interrupt level of the core |
| clr_we | input | 1 | Write-one-to-clear strobe for pending bits |
| clr_wdata | input | REQ_W | Pending bits to clear (edge-type lines only) |
| pend_lvl_o | output | LVL_W | Highest eligible active level, 0 if none |
| irq_o | output | 1 | Interrupt request to the core |

## Verification
Every piece of internal state reaches the ports within four rising edges. A stuck or wrongly cleared pending bit shows as a wrong reported level, or as a request that lingers or vanishes once the request is changed and enough edges have passed. An enable or current-level register that is wrong shows one cycle after the write. A broken scan order or threshold comparison shows when several levels are active at once and the current level is moved between them. Edge-type state is exposed by clearing a bit while its request is held high and then watching that the level stays 0.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

   // bits needed to encode levels 0..n
   function automatic int lvl_bits(input int n);
      return (n < 1) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] async_i,
   output logic [W-1:0] sync_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("irqc_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] pipe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe_q <= '0;
      end else begin
         pipe_q <= {pipe_q[STAGES-2:0], async_i};
      end
   end

   assign sync_o = pipe_q[STAGES-1];

endmodule

// File: rtl/irqc_pend.sv
module irqc_pend #(
   parameter int                 REQ_W     = 8,
   parameter int                 NUM_IRQ   = 6,
   parameter logic [REQ_W-1:0]   EDGE_MASK = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REQ_W-1:0] sync_i,
   input  logic [REQ_W-1:0] clr_i,
   output logic [REQ_W-1:0] pend_o
);

   localparam logic [REQ_W-1:0] IMPL_MASK  = {REQ_W{1'b1}} >> (REQ_W - NUM_IRQ);
   localparam logic [REQ_W-1:0] EDGE_IMPL  = EDGE_MASK & IMPL_MASK;
   localparam logic [REQ_W-1:0] LEVEL_IMPL = ~EDGE_MASK & IMPL_MASK;

   logic [REQ_W-1:0] pend_bits;

   for (genvar i = 0; i < REQ_W; i++) begin : g_line
      if (i >= NUM_IRQ) begin : g_absent
         assign pend_bits[i] = 1'b0;
      end else if (EDGE_MASK[i]) begin : g_edge
         logic prev_q;
         logic bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prev_q <= 1'b0;
               bit_q  <= 1'b0;
            end else begin
               prev_q <= sync_i[i];
               // a fresh rising edge wins over a clear in the same cycle
               bit_q  <= (sync_i[i] & ~prev_q) | (bit_q & ~clr_i[i]);
            end
         end
         assign pend_bits[i] = bit_q;
      end else begin : g_level
         logic bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bit_q <= 1'b0;
            else        bit_q <= sync_i[i];
         end
         assign pend_bits[i] = bit_q;
      end
   end

   assign pend_o = pend_bits;

   // R1
   lvl_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend_o & LEVEL_IMPL) == ($past(sync_i) & LEVEL_IMPL)));

   // R2
   edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(pend_o) & ~$past(clr_i) & EDGE_IMPL) & ~pend_o) == '0));

endmodule

// File: rtl/irqc_arb.sv
module irqc_arb #(
   parameter int                               REQ_W     = 8,
   parameter int                               NUM_LVL   = 4,
   parameter int                               LVL_W     = 3,
   parameter logic [NUM_LVL-1:0][REQ_W-1:0]    LVL_MASKS = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REQ_W-1:0] eff_i,
   input  logic [LVL_W-1:0] cur_i,
   output logic [LVL_W-1:0] lvl_o,
   output logic             irq_o
);

   logic [LVL_W-1:0] nxt_lvl;

   // scan from the top level down, stop at the first eligible active one
   always_comb begin
      nxt_lvl = '0;
      for (int l = NUM_LVL; l >= 1; l--) begin
         if (nxt_lvl == '0 && l > int'(cur_i) && |(LVL_MASKS[l-1] & eff_i)) begin
            nxt_lvl = LVL_W'(l);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_o <= '0;
         irq_o <= 1'b0;
      end else begin
         lvl_o <= nxt_lvl;
         irq_o <= (nxt_lvl != '0);
      end
   end

   // R6
   above_cur_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (lvl_o > $past(cur_i)));

   // R9
   lvl_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(eff_i) && $stable(cur_i)) |=> $stable(lvl_o));

endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl #(
   parameter int                               REQ_W     = 8,
   parameter int                               NUM_IRQ   = 6,
   parameter int                               NUM_LVL   = 4,
   parameter logic [REQ_W-1:0]                 EDGE_MASK = 8'h2A,
   parameter logic [NUM_LVL-1:0][REQ_W-1:0]    LVL_MASKS = {8'h30, 8'h08, 8'h06, 8'hC1},
   localparam int                              LVL_W     = irqc_pkg::lvl_bits(NUM_LVL)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REQ_W-1:0] req_i,
   input  logic             en_we,
   input  logic [REQ_W-1:0] en_wdata,
   input  logic             cur_we,
   input  logic [LVL_W-1:0] cur_wdata,
   input  logic             clr_we,
   input  logic [REQ_W-1:0] clr_wdata,
   output logic [LVL_W-1:0] pend_lvl_o,
   output logic             irq_o
);

   if (NUM_IRQ < 1 || NUM_IRQ > REQ_W) begin : g_bad_irq
      $error("irq_level_ctrl: NUM_IRQ must be within 1..REQ_W");
   end
   if (NUM_LVL < 1) begin : g_bad_lvl
      $error("irq_level_ctrl: NUM_LVL must be at least 1");
   end

   logic [REQ_W-1:0] en_q;
   logic [LVL_W-1:0] cur_q;
   logic [REQ_W-1:0] sync_req;
   logic [REQ_W-1:0] pend;
   logic [REQ_W-1:0] clr_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         cur_q <= '0;
      end else begin
         if (en_we)  en_q  <= en_wdata;
         if (cur_we) cur_q <= cur_wdata;
      end
   end

   assign clr_mask = clr_we ? clr_wdata : '0;

   irqc_sync #(
      .W      (REQ_W),
      .STAGES (2)
   ) i_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (req_i),
      .sync_o  (sync_req)
   );

   irqc_pend #(
      .REQ_W     (REQ_W),
      .NUM_IRQ   (NUM_IRQ),
      .EDGE_MASK (EDGE_MASK)
   ) i_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .sync_i (sync_req),
      .clr_i  (clr_mask),
      .pend_o (pend)
   );

   irqc_arb #(
      .REQ_W     (REQ_W),
      .NUM_LVL   (NUM_LVL),
      .LVL_W     (LVL_W),
      .LVL_MASKS (LVL_MASKS)
   ) i_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .eff_i (pend & en_q),
      .cur_i (cur_q),
      .lvl_o (pend_lvl_o),
      .irq_o (irq_o)
   );

endmodule

// File: tb/test_irq_level_ctrl.sv
`timescale 1ns/1ps
module test_irq_level_ctrl;

   localparam int REQ_W = 8;
   localparam int LVL_W = 3;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [REQ_W-1:0] req_i = '0;
   logic             en_we = 1'b0;
   logic [REQ_W-1:0] en_wdata = '0;
   logic             cur_we = 1'b0;
   logic [LVL_W-1:0] cur_wdata = '0;
   logic             clr_we = 1'b0;
   logic [REQ_W-1:0] clr_wdata = '0;
   logic [LVL_W-1:0] pend_lvl_o;
   logic             irq_o;

   int total = 0;
   int bad   = 0;

   always #2.5 clk = ~clk;

   irq_level_ctrl i_irq_level_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_i      (req_i),
      .en_we      (en_we),
      .en_wdata   (en_wdata),
      .cur_we     (cur_we),
      .cur_wdata  (cur_wdata),
      .clr_we     (clr_we),
      .clr_wdata  (clr_wdata),
      .pend_lvl_o (pend_lvl_o),
      .irq_o      (irq_o)
   );

   task automatic check(input string tag, input int exp_lvl);
      int exp_irq;
      exp_irq = (exp_lvl != 0) ? 1 : 0;
      total++;
      if (int'(pend_lvl_o) != exp_lvl || int'(irq_o) != exp_irq) begin
         bad++;
         $display("FAIL %s: level=%0d irq=%0d expected level=%0d irq=%0d",
                  tag, pend_lvl_o, irq_o, exp_lvl, exp_irq);
      end
   endtask

   task automatic cycles(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic set_req(input int line, input logic val);
      @(negedge clk);
      req_i[line] = val;
   endtask

   task automatic wr_en(input logic [REQ_W-1:0] v);
      @(negedge clk); en_we = 1'b1; en_wdata = v;
      @(negedge clk); en_we = 1'b0;
   endtask

   task automatic wr_cur(input int v);
      @(negedge clk); cur_we = 1'b1; cur_wdata = LVL_W'(v);
      @(negedge clk); cur_we = 1'b0;
   endtask

   task automatic wr_clr(input logic [REQ_W-1:0] v);
      @(negedge clk); clr_we = 1'b1; clr_wdata = v;
      @(negedge clk); clr_we = 1'b0;
   endtask

   task automatic t_reset();
      check("R7 reset state", 0);
      wr_en('1);
      wr_cur(0);
      cycles(3);
      check("R7 enabled but nothing pending", 0);
   endtask

   task automatic t_level_line();
      set_req(0, 1'b1); cycles(6);
      check("R1 level line 0 asserted", 1);
      set_req(0, 1'b0); cycles(6);
      check("R1 level line 0 released", 0);
   endtask

   task automatic t_latency();
      set_req(2, 1'b1);
      cycles(3);
      check("R9 request not yet visible after 3 edges", 0);
      cycles(1);
      check("R9 request visible on 4th edge", 2);
      @(negedge clk); cur_we = 1'b1; cur_wdata = 3'd2;
      @(negedge clk); cur_we = 1'b0;
      #1;
      check("R9 current-level write not yet visible", 2);
      cycles(1);
      check("R9 current-level write visible on 2nd edge", 0);
      wr_cur(0);
      set_req(2, 1'b0); cycles(6);
      check("R1 line 2 released", 0);
   endtask

   task automatic t_edge_line();
      set_req(1, 1'b1);
      set_req(1, 1'b0);
      cycles(6);
      check("R2 edge line 1 stays pending after pulse", 2);
      wr_clr(8'h02); cycles(2);
      check("R3 clear port drops edge line 1", 0);
   endtask

   task automatic t_clear_level();
      set_req(0, 1'b1); cycles(6);
      check("R1 level line 0 pending", 1);
      wr_clr(8'h01); cycles(3);
      check("R3 clear of level line 0 has no effect", 1);
      set_req(0, 1'b0); cycles(6);
   endtask

   task automatic t_edge_hold();
      set_req(3, 1'b1); cycles(6);
      check("R2 edge line 3 pending", 3);
      wr_clr(8'h08); cycles(4);
      check("R10 held request does not re-set after clear", 0);
      set_req(3, 1'b0); cycles(4);
      set_req(3, 1'b1); cycles(6);
      check("R10 new rising edge sets line 3 again", 3);
      wr_clr(8'h08);
      set_req(3, 1'b0); cycles(6);
      check("R3 line 3 cleared", 0);
   endtask

   task automatic t_enable();
      wr_en('0);
      set_req(5, 1'b1);
      set_req(5, 1'b0);
      cycles(6);
      check("R4 disabled pending line gives no request", 0);
      wr_en(8'h20); cycles(1);
      check("R4 enabling a kept pending line raises level 4", 4);
      wr_clr(8'h20); cycles(2);
      check("R3 line 5 cleared", 0);
      wr_en('1);
   endtask

   task automatic t_priority();
      set_req(0, 1'b1);
      set_req(2, 1'b1);
      set_req(4, 1'b1);
      cycles(6);
      check("R5 highest of levels 1,2,4", 4);
      set_req(4, 1'b0); cycles(6);
      check("R5 highest of levels 1,2", 2);
      set_req(2, 1'b0); cycles(6);
      check("R5 only level 1", 1);
   endtask

   task automatic t_threshold();
      set_req(2, 1'b1); cycles(6);
      wr_cur(1); cycles(1);
      check("R6 current 1 keeps level 2", 2);
      wr_cur(2); cycles(1);
      check("R6 current equal to top level blocks it", 0);
      wr_cur(0); cycles(1);
      check("R6 current 0 restores level 2", 2);
      set_req(4, 1'b1); cycles(6);
      wr_cur(4); cycles(1);
      check("R6 current at top level blocks all", 0);
      wr_cur(0);
      set_req(0, 1'b0);
      set_req(2, 1'b0);
      set_req(4, 1'b0);
      cycles(6);
      check("R7 all released", 0);
   endtask

   task automatic t_ignored();
      set_req(6, 1'b1);
      set_req(7, 1'b1);
      cycles(6);
      check("R8 lines 6 and 7 ignored", 0);
      set_req(6, 1'b0);
      set_req(7, 1'b0);
      cycles(6);
      check("R8 still idle after release", 0);
   endtask

   initial begin
      #(5.0 * 100000);
      bad++;
      total++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      cycles(3);
      @(negedge clk) rst_n = 1'b1;
      cycles(1);
      t_reset();
      t_level_line();
      t_latency();
      t_edge_line();
      t_clear_level();
      t_edge_hold();
      t_enable();
      t_priority();
      t_threshold();
      t_ignored();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule